// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer between two clock domains. A producer writes words on its own clock and a consumer reads them on another clock. The two clocks may be unrelated or the same clock. Each side has an active-low select and an active-high enable. An access happens on a rising edge only when the select is low and the enable is high.

The write side reports whether it has room and gives an active-low warning when few free slots remain. The read side gives one status pin and an active-low warning when few words remain. Both warning thresholds are loaded once after reset. The read side works in one of two timing modes, fixed after reset. In standard mode the status pin means the memory holds data, and a read request loads the next word into the output register. In fall-through mode the next word moves into the output register by itself, and the status pin means that register holds a valid word.

Pointers cross between the domains in Gray code through two-stage synchronizers. Every flag is derived in its own domain from its local pointer and the synchronized remote pointer.

Top module: `fifo_dc`

## Requirements
- R1: Words leave the read port in the same order they were accepted at the write port. rdata_o changes only on an edge that loads a word.
- R2: A write is accepted on a wclk_i rising edge only when wcs_ni=0 and wen_i=1. A read request counts only when rcs_ni=0 and ren_i=1.
- R3: wr_ready_o is 0 exactly when the memory holds 2^AW words as seen by the write side. A write attempted while wr_ready_o=0 is dropped.
- R4: In standard mode, a read request while rd_stat_o=0 leaves rdata_o and the read pointer unchanged.
- R5: wr_afull_no is 0 when the free slot count (2^AW minus the words seen by the write side) is less than or equal to the captured full threshold.
- R6: rd_aempty_no is 0 when the stored word count is less than or equal to the captured empty threshold. The stored count is the memory count seen by the read side, plus one in fall-through mode when the output register is valid.
- R7: In standard mode (fwft_sel_i=0 at capture), rd_stat_o=1 means the memory holds at least one word. An accepted read puts the next word on rdata_o after that same edge.
- R8: In fall-through mode (fwft_sel_i=1 at capture), the oldest word is loaded into rdata_o with no read request, and rd_stat_o=1 marks it valid. A read request while valid consumes it.
- R9: The mode and the empty threshold are captured on the first rclk_i edge after reset release. The full threshold is captured on the first wclk_i edge after reset release. Later changes to these inputs have no effect.
- R10: A write accepted at write edge k shows on the read side after read edge k+2 when both clocks are the same. In standard mode rd_stat_o rises then. In fall-through mode the word reaches rdata_o one edge later, at k+3.
- R11: While rst_ni=0, the outputs are: wr_ready_o=1, wr_afull_no=1, rd_stat_o=0, rd_aempty_no=0, rdata_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| fwft_sel_i | input | 1 | Mode select, captured after reset: 1 = fall-through, 0 = standard |
| ae_off_i | input | AW+1 | Almost-empty threshold, captured after reset |
| af_off_i | input | AW+1 | Almost-full threshold, captured after reset |
| wcs_ni | input | 1 | Write-side select, active low |
| wen_i | input | 1 | Write enable |
| wdata_i | input | DW | Write data |
| wr_ready_o | output | 1 | Room available for a write |
| wr_afull_no | output | 1 | Almost-full warning, active low |
| rcs_ni | input | 1 | Read-side select, active low |
| ren_i | input | 1 | Read enable |
| rdata_o | output | DW | Read data register |
| rd_stat_o | output | 1 | Standard mode: not empty. Fall-through mode: output valid |
| rd_aempty_no | output | 1 | Almost-empty warning, active low |

## Verification
A corrupted pointer or a lost synchronizer stage shows up at the ports within a cycle or two. The bench then sees a flag edge at the wrong cycle or a word out of order on rdata_o. The bench checks this against a queue-based model that knows the exact synchronizer latency. A wrong threshold comparison shows as a warning flag that is off by one word when the count crosses the threshold. A mode register that does not hold shows on rd_stat_o once the memory drains while a word still waits in the output register.

// File: rtl/fifo_dc_pkg.sv
package fifo_dc_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_dc_sync.sv
module fifo_dc_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fifo_dc_wr_ctl.sv
module fifo_dc_wr_ctl #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          en_i,
  input  logic [AW:0]   af_off_i,
  input  logic [AW:0]   rgray_sync_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          ready_o,
  output logic          afull_no
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin_q, wgray_q, wbin_n, rbin_s, used, free;
  logic [PW-1:0] af_q;
  logic          cfg_done_q, full;

  assign rbin_s = g2b(rgray_sync_i);
  assign used   = wbin_q - rbin_s;
  assign full   = (used == PW'(DEPTH));
  assign free   = PW'(DEPTH) - used;
  assign we_o   = !cs_ni && en_i && !full;
  assign wbin_n = wbin_q + {{(PW-1){1'b0}}, we_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q     <= '0;
      wgray_q    <= '0;
      af_q       <= '0;
      cfg_done_q <= 1'b0;
    end else begin
      if (!cfg_done_q) begin
        af_q       <= af_off_i;
        cfg_done_q <= 1'b1;
      end
      wbin_q  <= wbin_n;
      wgray_q <= wbin_n ^ (wbin_n >> 1);
    end
  end

  assign waddr_o  = wbin_q[AW-1:0];
  assign wgray_o  = wgray_q;
  assign ready_o  = !full;
  assign afull_no = !(free <= af_q);
endmodule

// File: rtl/fifo_dc_rd_ctl.sv
module fifo_dc_rd_ctl
  import fifo_dc_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          en_i,
  input  logic          fwft_sel_i,
  input  logic [AW:0]   ae_off_i,
  input  logic [AW:0]   wgray_sync_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          stat_o,
  output logic          aempty_no
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  rd_mode_e      mode_q;
  logic          cfg_done_q, ov_q, ov_n;
  logic [PW-1:0] rbin_q, rgray_q, rbin_n, wbin_s, cnt, ae_q;
  logic [PW:0]   stored;
  logic [DW-1:0] rdata_q;
  logic          fwft, nempty, rd_try, pop, load;

  assign wbin_s = g2b(wgray_sync_i);
  assign cnt    = wbin_s - rbin_q;
  assign nempty = (cnt != '0);
  assign fwft   = (mode_q == MODE_FWFT);
  assign rd_try = !cs_ni && en_i;

  // fall-through: refill whenever the output slot is free or being consumed
  always_comb begin
    if (fwft) begin
      pop  = ov_q && rd_try;
      load = nempty && (!ov_q || rd_try);
      ov_n = load ? 1'b1 : (pop ? 1'b0 : ov_q);
    end else begin
      pop  = 1'b0;
      load = rd_try && nempty;
      ov_n = 1'b0;
    end
  end

  assign rbin_n = rbin_q + {{(PW-1){1'b0}}, load};
  assign stored = {1'b0, cnt} + {{PW{1'b0}}, ov_q & fwft};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_STD;
      ae_q       <= '0;
      cfg_done_q <= 1'b0;
      rbin_q     <= '0;
      rgray_q    <= '0;
      rdata_q    <= '0;
      ov_q       <= 1'b0;
    end else begin
      if (!cfg_done_q) begin
        mode_q     <= rd_mode_e'(fwft_sel_i);
        ae_q       <= ae_off_i;
        cfg_done_q <= 1'b1;
      end
      if (load) rdata_q <= mem_rdata_i;
      rbin_q  <= rbin_n;
      rgray_q <= rbin_n ^ (rbin_n >> 1);
      ov_q    <= ov_n;
    end
  end

  assign raddr_o   = rbin_q[AW-1:0];
  assign rgray_o   = rgray_q;
  assign rdata_o   = rdata_q;
  assign stat_o    = fwft ? ov_q : nempty;
  assign aempty_no = !(stored <= {1'b0, ae_q});
endmodule

// File: rtl/fifo_dc.sv
module fifo_dc #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_sel_i,
  input  logic [AW:0]   ae_off_i,
  input  logic [AW:0]   af_off_i,
  input  logic          wcs_ni,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wr_ready_o,
  output logic          wr_afull_no,
  input  logic          rcs_ni,
  input  logic          ren_i,
  output logic [DW-1:0] rdata_o,
  output logic          rd_stat_o,
  output logic          rd_aempty_no
);
  localparam int DEPTH = 1 << AW;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_rd;

  fifo_dc_wr_ctl #(.AW(AW)) u_wr (
    .clk_i       (wclk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (wcs_ni),
    .en_i        (wen_i),
    .af_off_i    (af_off_i),
    .rgray_sync_i(rgray_s),
    .we_o        (we),
    .waddr_o     (waddr),
    .wgray_o     (wgray),
    .ready_o     (wr_ready_o),
    .afull_no    (wr_afull_no)
  );

  fifo_dc_sync #(.W(AW + 1)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray),
    .q_o   (rgray_s)
  );

  fifo_dc_sync #(.W(AW + 1)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray),
    .q_o   (wgray_s)
  );

  always_ff @(posedge wclk_i) begin
    if (we) mem_q[waddr] <= wdata_i;
  end

  assign mem_rd = mem_q[raddr];

  fifo_dc_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .clk_i       (rclk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (rcs_ni),
    .en_i        (ren_i),
    .fwft_sel_i  (fwft_sel_i),
    .ae_off_i    (ae_off_i),
    .wgray_sync_i(wgray_s),
    .mem_rdata_i (mem_rd),
    .raddr_o     (raddr),
    .rgray_o     (rgray),
    .rdata_o     (rdata_o),
    .stat_o      (rd_stat_o),
    .aempty_no   (rd_aempty_no)
  );
endmodule

// File: rtl/fifo_dc_chk.sv
module fifo_dc_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wcs_ni,
  input logic          wen_i,
  input logic          wr_ready_i,
  input logic          wr_afull_ni,
  input logic [AW:0]   wbin_i,
  input logic          rcs_ni,
  input logic          ren_i,
  input logic          rd_stat_i,
  input logic          rd_aempty_ni,
  input logic [DW-1:0] rdata_i,
  input logic [AW:0]   rbin_i,
  input logic          fwft_i,
  input logic          rcfg_done_i
);
  // R3
  a_r3_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wr_ready_i && !wcs_ni && wen_i) |=> $stable(wbin_i));

  // R5
  a_r5_full_implies_afull: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !wr_ready_i |-> !wr_afull_ni);

  // R4
  a_r4_no_underflow: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!fwft_i && !rd_stat_i && !rcs_ni && ren_i) |=> ($stable(rbin_i) && $stable(rdata_i)));

  // R6
  a_r6_empty_implies_aempty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!fwft_i && !rd_stat_i) |-> !rd_aempty_ni);

  // R8
  a_r8_fwft_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (fwft_i && rd_stat_i && !(!rcs_ni && ren_i)) |=> (rd_stat_i && $stable(rdata_i)));

  // R9
  a_r9_mode_static: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rcfg_done_i |=> $stable(fwft_i));
endmodule

bind fifo_dc fifo_dc_chk #(.DW(DW), .AW(AW)) chk_i (
  .wclk_i      (wclk_i),
  .rclk_i      (rclk_i),
  .rst_ni      (rst_ni),
  .wcs_ni      (wcs_ni),
  .wen_i       (wen_i),
  .wr_ready_i  (wr_ready_o),
  .wr_afull_ni (wr_afull_no),
  .wbin_i      (u_wr.wbin_q),
  .rcs_ni      (rcs_ni),
  .ren_i       (ren_i),
  .rd_stat_i   (rd_stat_o),
  .rd_aempty_ni(rd_aempty_no),
  .rdata_i     (rdata_o),
  .rbin_i      (u_rd.rbin_q),
  .fwft_i      (u_rd.mode_q == fifo_dc_pkg::MODE_FWFT),
  .rcfg_done_i (u_rd.cfg_done_q)
);

// File: tb/fifo_dc_tb_top.sv
`timescale 1ns/1ps
module fifo_dc_tb_top;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fwft_sel = 1'b0;
  logic [AW:0]   ae_off = '0, af_off = '0;
  logic          wcs_n = 1'b1, wen = 1'b0, rcs_n = 1'b1, ren = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          wr_ready, wr_afull_n, rd_stat, rd_aempty_n;
  logic [DW-1:0] rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fifo_dc #(.DW(DW), .AW(AW)) dut_i (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n),
    .fwft_sel_i(fwft_sel), .ae_off_i(ae_off), .af_off_i(af_off),
    .wcs_ni(wcs_n), .wen_i(wen), .wdata_i(wdata),
    .wr_ready_o(wr_ready), .wr_afull_no(wr_afull_n),
    .rcs_ni(rcs_n), .ren_i(ren), .rdata_o(rdata),
    .rd_stat_o(rd_stat), .rd_aempty_no(rd_aempty_n)
  );

  // behavioural reference
  logic [DW-1:0] q[$];
  int m_wptr, m_rptr, m_ws1, m_ws2, m_rs1, m_rs2, m_af, m_ae;
  bit m_ov, m_mode, m_wdone, m_rdone;
  logic [DW-1:0] m_data;
  int used, cnt, old_w, old_r;
  bit wacc, rtry, ld, pp;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_wptr = 0; m_rptr = 0; m_ws1 = 0; m_ws2 = 0; m_rs1 = 0; m_rs2 = 0;
      m_af = 0; m_ae = 0; m_ov = 0; m_mode = 0; m_wdone = 0; m_rdone = 0; m_data = '0;
    end else begin
      old_w = m_wptr; old_r = m_rptr;
      used = m_wptr - m_rs2;
      wacc = !wcs_n && wen && (used != DEPTH);
      cnt  = m_ws2 - m_rptr;
      rtry = !rcs_n && ren;
      if (m_mode) begin
        pp = m_ov && rtry;
        ld = (cnt > 0) && (!m_ov || rtry);
      end else begin
        pp = 0;
        ld = rtry && (cnt > 0);
      end
      if (ld) begin m_data = q.pop_front(); m_rptr++; end
      m_ov = m_mode ? (ld ? 1'b1 : (pp ? 1'b0 : m_ov)) : 1'b0;
      if (wacc) begin q.push_back(wdata); m_wptr++; end
      m_ws2 = m_ws1; m_ws1 = old_w;
      m_rs2 = m_rs1; m_rs1 = old_r;
      if (!m_wdone) begin m_af = int'(af_off); m_wdone = 1; end
      if (!m_rdone) begin m_mode = fwft_sel; m_ae = int'(ae_off); m_rdone = 1; end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 wr_ready", wr_ready, (m_wptr - m_rs2) != DEPTH);
      check("R5 almost-full", wr_afull_n, !((DEPTH - (m_wptr - m_rs2)) <= m_af));
      check(m_mode ? "R8 status" : "R7 status", rd_stat,
            m_mode ? m_ov : ((m_ws2 - m_rptr) > 0));
      check("R6 almost-empty", rd_aempty_n,
            !(((m_ws2 - m_rptr) + (m_mode ? int'(m_ov) : 0)) <= m_ae));
      check("R1 rdata", rdata, m_data);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle();
    wcs_n = 1'b1; wen = 1'b0; rcs_n = 1'b1; ren = 1'b0;
  endtask

  task automatic do_reset(input bit mode, input int ae, input int af);
    @(negedge clk);
    rst_n = 1'b0; idle();
    fwft_sel = mode; ae_off = (AW+1)'(ae); af_off = (AW+1)'(af);
    cyc(3);
    // R11 reset values
    check("R11 wr_ready", wr_ready, 1);
    check("R11 almost-full", wr_afull_n, 1);
    check("R11 status", rd_stat, 0);
    check("R11 almost-empty", rd_aempty_n, 0);
    check("R11 rdata", rdata, 0);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic traffic(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      wcs_n = ((i + seed) % 5 == 4);
      wen   = ((i + seed) % 3 != 2);
      rcs_n = ((i * 3 + seed) % 7 == 6);
      ren   = ((i + 2 * seed) % 4 != 3);
      wdata = DW'(i * 13 + seed);
      @(negedge clk);
    end
    idle();
  endtask

  initial begin
    // ---------------- standard mode ----------------
    do_reset(1'b0, 2, 3);
    wcs_n = 0; wen = 1; wdata = 8'hA5;
    @(negedge clk); idle();
    check("R10 status after k", rd_stat, 0);
    @(negedge clk);
    check("R10 status after k+1", rd_stat, 0);
    @(negedge clk);
    check("R10 status after k+2", rd_stat, 1);
    // writes with select high must be dropped
    wcs_n = 1; wen = 1; wdata = 8'h11;
    cyc(4);
    wcs_n = 0; wen = 0;
    cyc(2);
    idle(); cyc(3);
    rcs_n = 0; ren = 1;
    @(negedge clk); idle();
    check("R7 rdata after read", rdata, 8'hA5);
    check("R2 status empty, gated writes dropped", rd_stat, 0);
    // read while empty
    rcs_n = 0; ren = 1;
    cyc(3); idle();
    check("R4 rdata held on empty read", rdata, 8'hA5);
    // overfill
    for (int i = 0; i < DEPTH + 4; i++) begin
      wcs_n = 0; wen = 1; wdata = DW'(8'h30 + i);
      @(negedge clk);
    end
    idle(); cyc(3);
    check("R3 full, ready low", wr_ready, 0);
    check("R5 full, almost-full low", wr_afull_n, 0);
    // drain, verify first and order via model
    rcs_n = 0; ren = 1;
    @(negedge clk);
    check("R1 first word after overfill", rdata, 8'h30);
    cyc(DEPTH + 3); idle(); cyc(3);
    check("R3 dropped words never appear", rdata, 8'h30 + DEPTH - 1);
    traffic(400, 1);
    cyc(4);
    rcs_n = 0; ren = 1; cyc(DEPTH + 4); idle(); cyc(3);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1, 1, 5);
    wcs_n = 0; wen = 1; wdata = 8'h5C;
    @(negedge clk); idle();
    cyc(2);
    check("R10 fwft not yet valid after k+2", rd_stat, 0);
    @(negedge clk);
    check("R8 valid without read after k+3", rd_stat, 1);
    check("R8 word preloaded", rdata, 8'h5C);
    // change static inputs after capture
    fwft_sel = 1'b0; ae_off = '1; af_off = '0;
    cyc(5);
    check("R9 mode kept, status still valid", rd_stat, 1);
    check("R9 threshold kept, almost-empty", rd_aempty_n, 0);
    rcs_n = 0; ren = 1;
    @(negedge clk); idle();
    check("R8 consumed word clears status", rd_stat, 0);
    for (int i = 0; i < DEPTH + 3; i++) begin
      wcs_n = 0; wen = 1; wdata = DW'(8'h80 + i);
      @(negedge clk);
    end
    idle(); cyc(4);
    check("R3 fwft full", wr_ready, 0);
    check("R8 head of burst", rdata, 8'h80);
    traffic(500, 3);
    cyc(4);
    rcs_n = 0; ren = 1; cyc(DEPTH + 6); idle(); cyc(3);
    check("R8 drained", rd_stat, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule